// File: doc/BRIEF.md
# Multi-format serial audio port

This block is a stereo serial audio port that runs as a clock target. An external master supplies the bit clock and the frame clock. The block oversamples both clocks, together with the serial data input, in the system clock domain. On the receive side it gathers the left and right samples of each frame into parallel words. It presents the pair with a one-cycle valid pulse. On the transmit side it places two parallel words on the serial output line, timed so that the far end can sample them on the rising bit clock edge.

Two register inputs set the framing and the sample width. The framing choices are I2S, left-justified and right-justified. The sample width is 16, 18, 20 or 24 bits. Each channel has a fixed slot of 32 bit-clock periods, so a frame is 64 periods long. Where a sample sits inside its slot depends on both settings. A right-justified sample always ends on the last period of its slot. Setting changes and new transmit words take effect only at the start of a frame. An update written in the middle of a frame therefore cannot split a sample.

Periods inside a slot are counted from 0. Period 0 is the bit-clock period that starts at the falling bit clock edge on which the frame clock changes. The receiver samples on rising bit clock edges. The transmitter updates its output after falling edges.

Top module: `sap_top`

## Requirements
- R1: With framing code 1 (left-justified) or code 3, which behaves like code 1, the left channel is the slot in which the frame clock is high. The sample MSB sits in period 0 of the slot, and the following bits sit in the periods after it, MSB first.
- R2: With framing code 0 (I2S), the left channel is the slot in which the frame clock is low. The sample MSB sits in period 1 of the slot.
- R3: With framing code 2 (right-justified), the left channel is the slot in which the frame clock is high. A sample of W bits starts in period 32−W, so its LSB always sits in period 31. This places the MSB in period 8 for 24 bits, period 12 for 20 bits, period 14 for 18 bits and period 16 for 16 bits.
- R4: The word-length code selects the sample width: 0 gives 16 bits, 1 gives 18, 2 gives 20 and 3 gives 24. A received sample is placed MSB-first in bits 23 downward of its 24-bit word, and the unused low bits read 0. A transmit word supplies its top W bits, starting from bit 23.
- R5: After the last sample bit of the right channel has been captured, rx_valid is high for exactly one system clock cycle. In that same cycle rx_left and rx_right take the new pair. At all other times they hold their value.
- R6: sdout changes only after a falling bit clock edge. It carries the latched transmit word in the periods named by R1 to R4, and it is driven low in every other period of the slot.
- R7: tx_left and tx_right are sampled at the start of each frame. A change to them during a frame has no effect on sdout until the next frame.
- R8: A frame starts when the frame clock moves to the left-channel level of the requested framing code. cfg_fmt and cfg_wl are taken on at that point only. A change made during a frame leaves that frame decoded and sent with the old settings.
- R9: After reset, rx_valid, sdout, rx_left and rx_right are 0. sdout stays low and no valid pulse appears until the first frame start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; oversamples the serial clocks |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | Bit clock from the external master |
| lrclk | input | 1 | Frame clock from the external master |
| sdin | input | 1 | Serial receive data |
| sdout | output | 1 | Serial transmit data |
| cfg_fmt | input | 2 | Framing: 0 I2S, 1 left-justified, 2 right-justified, 3 as 1 |
| cfg_wl | input | 2 | Sample width: 0 16, 1 18, 2 20, 3 24 bits |
| tx_left | input | 24 | Left transmit word, MSB-aligned |
| tx_right | input | 24 | Right transmit word, MSB-aligned |
| rx_left | output | 24 | Last received left sample, MSB-aligned |
| rx_right | output | 24 | Last received right sample, MSB-aligned |
| rx_valid | output | 1 | One-cycle pulse when a new pair is presented |

## Verification
At a frame start, three events fall in the same system clock cycle. The requested settings are taken on, the transmit words are latched, and the first bit of the new frame is driven. The first bit must therefore already follow the new settings and the new words. The bench provokes this by changing the framing, the sample width and the transmit words from one frame to the next, including changes that swap which frame clock level means left. It judges the result by comparing each received slot bit by bit with the pattern the new settings call for. This catches a stale MSB in period 0 for left-justified framing, or stray leading bits for right-justified framing. A separate test changes the settings and the transmit words in the middle of a frame. That frame must still be decoded and sent with the old values, and only the next frame may show the new ones.

// File: rtl/sap_pkg.sv
package sap_pkg;

  localparam int WORD_W   = 24;
  localparam int SLOT_LEN = 32;
  localparam int IDX_W    = $clog2(SLOT_LEN);
  localparam int POS_W    = $clog2(WORD_W);

  localparam logic [1:0] FMT_I2S = 2'd0;
  localparam logic [1:0] FMT_LJ  = 2'd1;
  localparam logic [1:0] FMT_RJ  = 2'd2;

  // number of sample bits for a word-length code
  function automatic logic [6:0] wl_bits(input logic [1:0] wl);
    case (wl)
      2'd0:    return 7'd16;
      2'd1:    return 7'd18;
      2'd2:    return 7'd20;
      default: return 7'd24;
    endcase
  endfunction

  // slot period that carries the MSB
  function automatic logic [6:0] slot_start(input logic [1:0] fmt, input logic [1:0] wl);
    case (fmt)
      FMT_I2S: return 7'd1;
      FMT_RJ:  return 7'(SLOT_LEN) - wl_bits(wl);
      default: return 7'd0;
    endcase
  endfunction

  function automatic logic is_left(input logic [1:0] fmt, input logic lr);
    return (fmt == FMT_I2S) ? ~lr : lr;
  endfunction

  function automatic logic in_word(input logic [IDX_W-1:0] idx, input logic [1:0] fmt,
                                   input logic [1:0] wl);
    logic [6:0] i7;
    i7 = 7'(idx);
    return (i7 >= slot_start(fmt, wl)) && (i7 < slot_start(fmt, wl) + wl_bits(wl));
  endfunction

  function automatic logic last_bit(input logic [IDX_W-1:0] idx, input logic [1:0] fmt,
                                    input logic [1:0] wl);
    return 7'(idx) == slot_start(fmt, wl) + wl_bits(wl) - 7'd1;
  endfunction

  // position inside the 24-bit word for a slot period within the sample
  function automatic logic [POS_W-1:0] bit_pos(input logic [IDX_W-1:0] idx, input logic [1:0] fmt,
                                               input logic [1:0] wl);
    logic [6:0] p;
    p = 7'(WORD_W - 1) - (7'(idx) - slot_start(fmt, wl));
    return p[POS_W-1:0];
  endfunction

endpackage

// File: rtl/sap_front.sv
module sap_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk,
  input  logic lrclk,
  input  logic sdin,
  output logic srst_n,
  output logic bclk_rise,
  output logic bclk_fall,
  output logic lr_s,
  output logic din_s
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [1:0]   rst_sh_q;
  logic [TOP:0] bclk_sh_q, lr_sh_q, din_sh_q;
  logic [TOP:0] bclk_sh_d, lr_sh_d, din_sh_d;
  logic         bclk_last_q;

  // reset: asserted at once, released through two flops
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh_q <= 2'b00;
    else        rst_sh_q <= {rst_sh_q[0], 1'b1};
  end
  assign srst_n = rst_sh_q[1];

  always_comb begin
    bclk_sh_d = {bclk_sh_q[TOP-1:0], bclk};
    lr_sh_d   = {lr_sh_q[TOP-1:0], lrclk};
    din_sh_d  = {din_sh_q[TOP-1:0], sdin};
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      bclk_sh_q   <= '0;
      lr_sh_q     <= '0;
      din_sh_q    <= '0;
      bclk_last_q <= 1'b0;
    end else begin
      bclk_sh_q   <= bclk_sh_d;
      lr_sh_q     <= lr_sh_d;
      din_sh_q    <= din_sh_d;
      bclk_last_q <= bclk_sh_q[TOP];
    end
  end

  assign bclk_rise = bclk_sh_q[TOP] & ~bclk_last_q;
  assign bclk_fall = ~bclk_sh_q[TOP] & bclk_last_q;
  assign lr_s      = lr_sh_q[TOP];
  assign din_s     = din_sh_q[TOP];

endmodule

// File: rtl/sap_timer.sv
module sap_timer
  import sap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bclk_rise,
  input  logic             bclk_fall,
  input  logic             lr_s,
  input  logic [1:0]       cfg_fmt,
  input  logic [1:0]       cfg_wl,
  output logic [IDX_W-1:0] idx_nxt,
  output logic             rise_left,
  output logic             fall_left,
  output logic             load,
  output logic             framed,
  output logic [1:0]       act_fmt,
  output logic [1:0]       act_wl,
  output logic [1:0]       use_fmt,
  output logic [1:0]       use_wl
);

  logic [IDX_W-1:0] cnt_q, cnt_d;
  logic             lr_q, lr_d;
  logic             framed_q, framed_d;
  logic [1:0]       fmt_q, fmt_d, wl_q, wl_d;
  logic             new_slot;

  // period index of the period being entered (at a fall) or sampled (at a rise)
  assign new_slot = lr_s ^ lr_q;
  assign idx_nxt  = new_slot ? '0 : cnt_q + {{(IDX_W-1){1'b0}}, 1'b1};
  assign load     = bclk_fall & new_slot & is_left(cfg_fmt, lr_s);

  assign use_fmt   = load ? cfg_fmt : fmt_q;
  assign use_wl    = load ? cfg_wl : wl_q;
  assign fall_left = is_left(use_fmt, lr_s);
  assign rise_left = is_left(fmt_q, lr_s);
  assign act_fmt   = fmt_q;
  assign act_wl    = wl_q;
  assign framed    = framed_q;

  always_comb begin
    cnt_d    = cnt_q;
    lr_d     = lr_q;
    framed_d = framed_q;
    fmt_d    = fmt_q;
    wl_d     = wl_q;
    if (bclk_rise) begin
      cnt_d = idx_nxt;
      lr_d  = lr_s;
    end
    if (load) begin
      framed_d = 1'b1;
      fmt_d    = cfg_fmt;
      wl_d     = cfg_wl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      lr_q     <= 1'b0;
      framed_q <= 1'b0;
      fmt_q    <= FMT_LJ;
      wl_q     <= 2'd3;
    end else begin
      cnt_q    <= cnt_d;
      lr_q     <= lr_d;
      framed_q <= framed_d;
      fmt_q    <= fmt_d;
      wl_q     <= wl_d;
    end
  end

endmodule

// File: rtl/sap_rx.sv
module sap_rx
  import sap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_rise,
  input  logic              din_s,
  input  logic [IDX_W-1:0]  idx,
  input  logic              rise_left,
  input  logic              framed,
  input  logic [1:0]        fmt,
  input  logic [1:0]        wl,
  output logic [WORD_W-1:0] rx_left,
  output logic [WORD_W-1:0] rx_right,
  output logic              rx_valid
);

  logic [WORD_W-1:0] lbuf_q, lbuf_d, rbuf_q, rbuf_d;
  logic [WORD_W-1:0] out_l_q, out_l_d, out_r_q, out_r_d;
  logic [WORD_W-1:0] word_nxt;
  logic              valid_q, valid_d;
  logic              hit, fin;

  assign hit = in_word(idx, fmt, wl);

  always_comb begin
    word_nxt = (idx == '0) ? '0 : (rise_left ? lbuf_q : rbuf_q);
    if (hit) word_nxt[bit_pos(idx, fmt, wl)] = din_s;

    fin     = bclk_rise & framed & ~rise_left & hit & last_bit(idx, fmt, wl);
    lbuf_d  = lbuf_q;
    rbuf_d  = rbuf_q;
    out_l_d = out_l_q;
    out_r_d = out_r_q;
    valid_d = fin;
    if (bclk_rise && framed) begin
      if (rise_left) lbuf_d = word_nxt;
      else           rbuf_d = word_nxt;
    end
    if (fin) begin
      out_l_d = lbuf_q;
      out_r_d = word_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lbuf_q  <= '0;
      rbuf_q  <= '0;
      out_l_q <= '0;
      out_r_q <= '0;
      valid_q <= 1'b0;
    end else begin
      lbuf_q  <= lbuf_d;
      rbuf_q  <= rbuf_d;
      out_l_q <= out_l_d;
      out_r_q <= out_r_d;
      valid_q <= valid_d;
    end
  end

  assign rx_left  = out_l_q;
  assign rx_right = out_r_q;
  assign rx_valid = valid_q;

endmodule

// File: rtl/sap_tx.sv
module sap_tx
  import sap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_fall,
  input  logic              load,
  input  logic              framed,
  input  logic [IDX_W-1:0]  idx,
  input  logic              fall_left,
  input  logic [1:0]        fmt,
  input  logic [1:0]        wl,
  input  logic [WORD_W-1:0] tx_left,
  input  logic [WORD_W-1:0] tx_right,
  output logic              sdout
);

  logic [WORD_W-1:0] hold_l_q, hold_l_d, hold_r_q, hold_r_d;
  logic [WORD_W-1:0] word;
  logic              bit_v;
  logic              sd_q, sd_d;

  always_comb begin
    hold_l_d = hold_l_q;
    hold_r_d = hold_r_q;
    if (load) begin
      hold_l_d = tx_left;
      hold_r_d = tx_right;
    end
    // on the boundary cycle the words being latched are already in use
    word  = fall_left ? hold_l_d : hold_r_d;
    bit_v = in_word(idx, fmt, wl) ? word[bit_pos(idx, fmt, wl)] : 1'b0;
    sd_d  = sd_q;
    if (bclk_fall) sd_d = (framed | load) & bit_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_l_q <= '0;
      hold_r_q <= '0;
      sd_q     <= 1'b0;
    end else begin
      hold_l_q <= hold_l_d;
      hold_r_q <= hold_r_d;
      sd_q     <= sd_d;
    end
  end

  assign sdout = sd_q;

endmodule

// File: rtl/sap_top.sv
module sap_top
  import sap_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk,
  input  logic              lrclk,
  input  logic              sdin,
  output logic              sdout,
  input  logic [1:0]        cfg_fmt,
  input  logic [1:0]        cfg_wl,
  input  logic [WORD_W-1:0] tx_left,
  input  logic [WORD_W-1:0] tx_right,
  output logic [WORD_W-1:0] rx_left,
  output logic [WORD_W-1:0] rx_right,
  output logic              rx_valid
);

  logic             srst_n, bclk_rise, bclk_fall, lr_s, din_s;
  logic [IDX_W-1:0] idx_nxt;
  logic             rise_left, fall_left, load, framed;
  logic [1:0]       act_fmt, act_wl, use_fmt, use_wl;

  sap_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .lrclk(lrclk), .sdin(sdin),
    .srst_n(srst_n), .bclk_rise(bclk_rise), .bclk_fall(bclk_fall),
    .lr_s(lr_s), .din_s(din_s)
  );

  sap_timer u_timer (
    .clk(clk), .rst_n(srst_n), .bclk_rise(bclk_rise), .bclk_fall(bclk_fall),
    .lr_s(lr_s), .cfg_fmt(cfg_fmt), .cfg_wl(cfg_wl), .idx_nxt(idx_nxt),
    .rise_left(rise_left), .fall_left(fall_left), .load(load), .framed(framed),
    .act_fmt(act_fmt), .act_wl(act_wl), .use_fmt(use_fmt), .use_wl(use_wl)
  );

  sap_rx u_rx (
    .clk(clk), .rst_n(srst_n), .bclk_rise(bclk_rise), .din_s(din_s),
    .idx(idx_nxt), .rise_left(rise_left), .framed(framed),
    .fmt(act_fmt), .wl(act_wl),
    .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid)
  );

  sap_tx u_tx (
    .clk(clk), .rst_n(srst_n), .bclk_fall(bclk_fall), .load(load), .framed(framed),
    .idx(idx_nxt), .fall_left(fall_left), .fmt(use_fmt), .wl(use_wl),
    .tx_left(tx_left), .tx_right(tx_right), .sdout(sdout)
  );

endmodule

// File: rtl/sap_checker.sv
module sap_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        bclk_rise,
  input logic        bclk_fall,
  input logic        framed,
  input logic        sdout,
  input logic        rx_valid,
  input logic [23:0] rx_left,
  input logic [23:0] rx_right,
  input logic [1:0]  act_fmt,
  input logic [1:0]  act_wl
);

  p_valid_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  p_valid_after_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(bclk_rise));

  p_words_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> ($stable(rx_left) && $stable(rx_right)));

  p_sdout_after_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdout) |-> $past(bclk_fall));

  p_quiet_unframed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !framed |-> (!sdout && !rx_valid));

  p_cfg_at_boundary_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(act_fmt) || !$stable(act_wl)) |-> $past(bclk_fall));

endmodule

bind sap_top sap_checker u_sap_checker (
  .clk(clk), .rst_n(srst_n), .bclk_rise(bclk_rise), .bclk_fall(bclk_fall),
  .framed(framed), .sdout(sdout), .rx_valid(rx_valid), .rx_left(rx_left),
  .rx_right(rx_right), .act_fmt(act_fmt), .act_wl(act_wl)
);

// File: tb/sap_top_bench.sv
module sap_top_bench;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, bclk, lrclk, sdin, sdout, rx_valid;
  logic [1:0]  cfg_fmt, cfg_wl;
  logic [23:0] tx_left, tx_right, rx_left, rx_right;

  sap_top u_sap_top (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .lrclk(lrclk), .sdin(sdin), .sdout(sdout),
    .cfg_fmt(cfg_fmt), .cfg_wl(cfg_wl), .tx_left(tx_left), .tx_right(tx_right),
    .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  int bench_period = 0;
  bit bench_right  = 1'b0;
  bit prev_valid   = 1'b0;

  typedef struct packed {
    logic [23:0] l;
    logic [23:0] r;
    logic [5:0]  idx;
  } exp_t;
  exp_t scb[$];

  logic [1:0]  hook_kind;
  logic [23:0] hook_l, hook_r;
  logic [1:0]  hook_wl;

  function automatic int nbits(input logic [1:0] wl);
    case (wl)
      2'd0: return 16;
      2'd1: return 18;
      2'd2: return 20;
      default: return 24;
    endcase
  endfunction

  function automatic int start_of(input logic [1:0] fmt, input logic [1:0] wl);
    if (fmt == 2'd0) return 1;
    if (fmt == 2'd2) return 32 - nbits(wl);
    return 0;
  endfunction

  function automatic logic [23:0] trim(input logic [23:0] w, input logic [1:0] wl);
    return w & (24'hFFFFFF << (24 - nbits(wl)));
  endfunction

  function automatic logic [31:0] slot_pat(input logic [1:0] fmt, input logic [1:0] wl,
                                           input logic [23:0] w);
    logic [31:0] p;
    int st, n;
    st = start_of(fmt, wl);
    n  = nbits(wl);
    for (int k = 0; k < 32; k++)
      p[31-k] = (k >= st && k < st + n) ? w[23-(k-st)] : 1'b0;
    return p;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor for received pairs
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rx_valid === 1'b1) begin
        if (prev_valid) chk("R5 valid longer than one cycle", 32'd1, 32'd0);
        if (scb.size() == 0) begin
          chk("R5 R9 unexpected valid", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = scb.pop_front();
          chk("R4 R5 left word", {8'h0, rx_left}, {8'h0, e.l});
          chk("R4 R5 right word", {8'h0, rx_right}, {8'h0, e.r});
          chk("R5 valid position", {bench_right, 31'(bench_period)}, {1'b1, 31'(e.idx)});
        end
      end
      prev_valid = (rx_valid === 1'b1);
    end
  end

  // one bit-clock period of 12 system cycles; returns sdout sampled at the rise
  task automatic bperiod(input logic lr, input logic d, output logic q);
    @(negedge clk);
    bclk = 1'b0; lrclk = lr; sdin = d;
    repeat (6) @(negedge clk);
    q = sdout;
    bclk = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic run_slot(input logic lr, input logic [1:0] fmt, input logic [1:0] wl,
                          input logic [23:0] w, input bit is_right, input bit do_hook,
                          output logic [31:0] got);
    int st, n;
    st = start_of(fmt, wl);
    n  = nbits(wl);
    for (int k = 0; k < 32; k++) begin
      logic d, q;
      d = (k >= st && k < st + n) ? w[23-(k-st)] : 1'b0;
      if (do_hook && k == 5) begin
        if (hook_kind == 2'd1) begin tx_left = hook_l; tx_right = hook_r; end
        if (hook_kind == 2'd2) cfg_wl = hook_wl;
      end
      bench_period = k;
      bench_right  = is_right;
      bperiod(lr, d, q);
      got[31-k] = q;
    end
  endtask

  task automatic run_frame(input logic [1:0] fmt, input logic [1:0] wl,
                           input logic [23:0] rl, input logic [23:0] rr,
                           input logic [23:0] tl, input logic [23:0] tr,
                           input logic [23:0] el, input logic [23:0] er,
                           input logic [1:0] hk, input string tag);
    logic        lv;
    logic [31:0] g;
    cfg_fmt = fmt; cfg_wl = wl; tx_left = tl; tx_right = tr; hook_kind = hk;
    lv = (fmt == 2'd0) ? 1'b0 : 1'b1;
    if (lrclk == lv) run_slot(~lv, fmt, wl, 24'h0, 1'b0, 1'b0, g);
    scb.push_back('{trim(rl, wl), trim(rr, wl), 6'(start_of(fmt, wl) + nbits(wl) - 1)});
    run_slot(lv, fmt, wl, rl, 1'b0, hk != 2'd0, g);
    chk({tag, " R6 left slot on sdout"}, g, slot_pat(fmt, wl, el));
    run_slot(~lv, fmt, wl, rr, 1'b1, 1'b0, g);
    chk({tag, " R6 right slot on sdout"}, g, slot_pat(fmt, wl, er));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic q;
    rst_n = 1'b0; bclk = 1'b0; lrclk = 1'b0; sdin = 1'b0;
    cfg_fmt = 2'd1; cfg_wl = 2'd3; tx_left = '0; tx_right = '0;
    hook_kind = 2'd0; hook_l = '0; hook_r = '0; hook_wl = 2'd0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 reset rx_valid", {31'h0, rx_valid}, 32'd0);
    chk("R9 reset sdout", {31'h0, sdout}, 32'd0);
    chk("R9 reset rx_left", {8'h0, rx_left}, 32'd0);
    chk("R9 reset rx_right", {8'h0, rx_right}, 32'd0);
    tx_left = 24'hFFFFFF; tx_right = 24'hFFFFFF;
    for (int i = 0; i < 4; i++) begin
      bperiod(1'b0, 1'b1, q);
      chk("R9 idle sdout before first frame", {31'h0, q}, 32'd0);
    end

    run_frame(2'd1, 2'd3, 24'hA1B2C3, 24'h5E6F70, 24'h123456, 24'hABCDEF,
              24'h123456, 24'hABCDEF, 2'd0, "R1 LJ24");
    hook_l = 24'hFEDCBA; hook_r = 24'h0F1E2D;
    run_frame(2'd1, 2'd3, 24'h3C5A96, 24'hC3A569, 24'h135791, 24'h2468AC,
              24'h135791, 24'h2468AC, 2'd1, "R7 mid-frame tx change");
    hook_wl = 2'd0;
    run_frame(2'd1, 2'd3, 24'h8F0E1D, 24'h7A6B5C, 24'hFEDCBA, 24'h0F1E2D,
              24'hFEDCBA, 24'h0F1E2D, 2'd2, "R7 R8 mid-frame cfg change");
    run_frame(2'd1, 2'd0, 24'hF0F0F3, 24'h0F0F0C, 24'h9ABCDE, 24'h6D5E4F,
              24'h9ABCDE, 24'h6D5E4F, 2'd0, "R8 R4 LJ16");
    run_frame(2'd1, 2'd1, 24'hB6C7D8, 24'h49382F, 24'hDB6DB6, 24'h249249,
              24'hDB6DB6, 24'h249249, 2'd0, "R1 R4 LJ18");
    run_frame(2'd0, 2'd3, 24'hC0FFEE, 24'h5EED01, 24'hE1D2C3, 24'h1E2D3C,
              24'hE1D2C3, 24'h1E2D3C, 2'd0, "R2 R8 I2S24");
    run_frame(2'd0, 2'd2, 24'h87654F, 24'h2B3C4D, 24'hAAAAAA, 24'h555555,
              24'hAAAAAA, 24'h555555, 2'd0, "R2 R4 I2S20");
    run_frame(2'd0, 2'd0, 24'hFFFFFF, 24'h800001, 24'hC3C3C3, 24'h3C3C3C,
              24'hC3C3C3, 24'h3C3C3C, 2'd0, "R2 R4 I2S16");
    run_frame(2'd2, 2'd3, 24'hD1E2F3, 24'h2C3B4A, 24'h8E9FA0, 24'h715062,
              24'h8E9FA0, 24'h715062, 2'd0, "R3 R8 RJ24");
    run_frame(2'd2, 2'd2, 24'h6A7B8C, 24'h95A4B3, 24'hF1E2D3, 24'h0E1D2C,
              24'hF1E2D3, 24'h0E1D2C, 2'd0, "R3 R4 RJ20");
    run_frame(2'd2, 2'd1, 24'hE7D6C5, 24'h18293A, 24'hB4C5D6, 24'h4B3A29,
              24'hB4C5D6, 24'h4B3A29, 2'd0, "R3 R4 RJ18");
    run_frame(2'd2, 2'd0, 24'h9F8E7D, 24'h607182, 24'h5A5A5A, 24'hA5A5A5,
              24'h5A5A5A, 24'hA5A5A5, 2'd0, "R3 R4 RJ16");
    run_frame(2'd3, 2'd2, 24'h13579B, 24'hECA864, 24'h2F4E6D, 24'hD0B192,
              24'h2F4E6D, 24'hD0B192, 2'd0, "R1 code3 LJ20");

    repeat (4) @(negedge clk);
    chk("R5 every pair delivered", 32'(scb.size()), 32'd0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule